// File: doc/BRIEF.md
# SPI Master Burst Sequencer

This block is the serial core of an SPI master. Software configures clock polarity, clock phase, bit order, chip-select behaviour, a burst length and a transmit length, then pulses a start strobe. The engine clocks out the whole burst as 8-bit words on the serial clock and data-out pins. It samples the data-in pin on the edge that the phase setting selects. Each finished incoming word is either pushed into a receive FIFO or discarded. A busy flag stays high while the exchange runs. When the exchange ends, a single-cycle completion pulse is raised.

Only the first transmit-length words of the burst are popped from the transmit FIFO, which is first-word-fall-through. All later words go out as zero filler. The serial clock advances only on the cycles where an external divider asserts a half-period enable, so the engine has no divider of its own. Four chip-select lines are driven with a programmable active level. The selected line is either sequenced by the engine around the burst or forced to a level chosen by software.

Top module: `spi_burst_engine`

## Requirements
- R1: A start strobe is accepted only while `en` and `master_mode` are both 1, the engine is idle and `burst_len` is non-zero. Otherwise it has no effect: no SCLK edge, no pop and no done pulse. Once accepted, `busy` stays 1 until the exchange ends.
- R2: While idle, SCLK rests at the `cpol` level. An exchange produces exactly 16 × `burst_len` SCLK transitions, and each transition occurs on a cycle where `sclk_tick` was 1.
- R3: Each word is shifted MSB first when `lsb_first`=0 and LSB first when it is 1. With `cpha`=0, MOSI is valid before the leading (first) edge of each bit and changes on the trailing edge. With `cpha`=1, MOSI changes on the leading edge and is valid at the trailing edge.
- R4: Word k of the burst (counting from 0) is popped from the transmit FIFO only when k < `tx_len`. All later words are sent as 0x00 and do not pop.
- R5: If the transmit FIFO is empty when a word with k < `tx_len` is due, that word is sent as 0x00 and nothing is popped.
- R6: MISO is sampled on the leading edge when `cpha`=0 and on the trailing edge when `cpha`=1. Samples are assembled in the same bit order as transmission. Each complete word is presented on `rx_data` with a one-cycle `rx_push`.
- R7: When `drop_rx`=1, `rx_push` never rises.
- R8: In automatic mode (`cs_manual`=0), the line selected by `cs_sel` is at its active level on every SCLK edge of the exchange. It is asserted before the first edge and returns to the inactive level within one cycle after `done`.
- R9: The active level is low when `cs_active_low`=1 and high when it is 0. Unselected lines, and the selected line when no exchange runs, rest at the inactive level. When `cs_manual`=1, the selected line follows `cs_level` directly. After reset, all lines are 1.
- R10: `done` is high for exactly one cycle per accepted exchange, in the same cycle that `busy` falls.
- R11: Dropping `en` aborts an exchange. `busy` falls, SCLK returns to the `cpol` level, and no `done` pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| master_mode | input | 1 | Master mode select; must be 1 to start |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase |
| lsb_first | input | 1 | Shift LSB first |
| drop_rx | input | 1 | Discard received words |
| cs_manual | input | 1 | Manual chip-select override |
| cs_level | input | 1 | Level of the selected line in manual mode |
| cs_active_low | input | 1 | Chip selects are active low |
| cs_sel | input | clog2(NUM_CS) | Selected chip-select line |
| start | input | 1 | Exchange start strobe |
| burst_len | input | CNT_W | Total words clocked |
| tx_len | input | CNT_W | Words taken from the transmit FIFO |
| sclk_tick | input | 1 | Half-period enable from the clock divider |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head word |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_push | output | 1 | Receive FIFO push |
| rx_data | output | 8 | Received word |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_out | output | NUM_CS | Chip-select lines |
| busy | output | 1 | Exchange in progress (start bit readback) |
| done | output | 1 | Exchange complete pulse |

## Verification
The embedded properties check several rules on every cycle. `done` is a single cycle that coincides with `busy` falling. SCLK sits at the `cpol` level while idle. The automatic chip select is active on every non-idle SCLK level. A manual chip select follows its level input, and no push occurs while received words are being dropped. Other properties can only be shown by the bench's sweeps over phase, polarity and bit order, with varied burst length, transmit length and FIFO fill. These are the word contents on MOSI, the zero-filler and pop-count rules, the reassembly of MISO words and the edge count of each burst.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 8;
  localparam int HALF_W = $clog2(2 * WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } eng_state_t;
endpackage

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              emit,
  input  logic              lsb_first,
  output logic              mosi
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] src;

  assign src = load ? load_word : sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      mosi <= 1'b0;
    end else if (emit) begin
      if (lsb_first) begin
        mosi <= src[0];
        sh_q <= {1'b0, src[WORD_W-1:1]};
      end else begin
        mosi <= src[WORD_W-1];
        sh_q <= {src[WORD_W-2:0], 1'b0};
      end
    end else if (load) begin
      sh_q <= load_word;
    end
  end
endmodule

// File: rtl/spi_rx_deserializer.sv
module spi_rx_deserializer
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              last_bit,
  input  logic              lsb_first,
  input  logic              drop_rx,
  input  logic              miso,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_nx;

  assign sh_nx = lsb_first ? {miso, sh_q[WORD_W-1:1]} : {sh_q[WORD_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (sample) begin
        sh_q <= sh_nx;
        if (last_bit) begin
          rx_data <= sh_nx;
          rx_push <= !drop_rx;
        end
      end
    end
  end

  a_r7_no_push_when_dropping: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !$past(drop_rx));
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              manual,
  input  logic              level,
  input  logic              active_low,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_out <= '1;
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (SEL_W'(i) == sel)
          cs_out[i] <= manual ? level : (active ? !active_low : active_low);
        else
          cs_out[i] <= active_low;
      end
    end
  end

  a_r9_manual_follows_level: assert property (@(posedge clk) disable iff (rst)
    ($past(manual) && !$past(rst)) |-> cs_out[$past(sel)] == $past(level));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      master_mode,
  input  logic                      cpol,
  input  logic                      cpha,
  input  logic                      lsb_first,
  input  logic                      drop_rx,
  input  logic                      cs_manual,
  input  logic                      cs_level,
  input  logic                      cs_active_low,
  input  logic [$clog2(NUM_CS)-1:0] cs_sel,
  input  logic                      start,
  input  logic [CNT_W-1:0]          burst_len,
  input  logic [CNT_W-1:0]          tx_len,
  input  logic                      sclk_tick,
  input  logic                      tx_empty,
  input  logic [WORD_W-1:0]         tx_data,
  output logic                      tx_pop,
  output logic                      rx_push,
  output logic [WORD_W-1:0]         rx_data,
  input  logic                      miso,
  output logic                      sclk,
  output logic                      mosi,
  output logic [NUM_CS-1:0]         cs_out,
  output logic                      busy,
  output logic                      done
);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * WORD_W - 1);
  localparam logic [HALF_W-1:0] HALF_PREV = HALF_W'(2 * WORD_W - 2);

  eng_state_t        st;
  logic [HALF_W-1:0] half;
  logic [CNT_W-1:0]  bcnt;
  logic              sclk_r;

  logic go, edge_lead, edge_trail, word_end, last_word, next_load;
  logic [CNT_W-1:0]  next_idx;
  logic [WORD_W-1:0] load_word;
  logic emit, sample, last_sample;

  assign go         = start && en && master_mode && (st == ST_IDLE) && (burst_len != '0);
  assign edge_lead  = (st == ST_RUN) && sclk_tick && !half[0];
  assign edge_trail = (st == ST_RUN) && sclk_tick && half[0];
  assign word_end   = edge_trail && (half == HALF_LAST);
  assign last_word  = (bcnt == burst_len - CNT_W'(1));
  assign next_load  = go || (word_end && !last_word);
  assign next_idx   = go ? '0 : bcnt + CNT_W'(1);
  assign tx_pop     = next_load && (next_idx < tx_len) && !tx_empty;
  assign load_word  = tx_pop ? tx_data : '0;

  assign emit        = cpha ? edge_lead : (next_load || (edge_trail && half != HALF_LAST));
  assign sample      = cpha ? edge_trail : edge_lead;
  assign last_sample = cpha ? (half == HALF_LAST) : (half == HALF_PREV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      half   <= '0;
      bcnt   <= '0;
      sclk_r <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st     <= ST_IDLE;
        sclk_r <= cpol;
      end else begin
        unique case (st)
          ST_IDLE: begin
            sclk_r <= cpol;
            if (go) begin
              st   <= ST_LEAD;
              bcnt <= '0;
              half <= '0;
            end
          end
          ST_LEAD: if (sclk_tick) st <= ST_RUN;
          ST_RUN: if (sclk_tick) begin
            sclk_r <= half[0] ? cpol : !cpol;
            half   <= half + HALF_W'(1);
            if (half == HALF_LAST) begin
              if (last_word) st <= ST_TAIL;
              else           bcnt <= bcnt + CNT_W'(1);
            end
          end
          ST_TAIL: if (sclk_tick) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sclk = sclk_r;
  assign busy = (st != ST_IDLE);

  spi_tx_serializer u_tx (
    .clk(clk), .rst(rst), .load(next_load), .load_word(load_word),
    .emit(emit), .lsb_first(lsb_first), .mosi(mosi)
  );

  spi_rx_deserializer u_rx (
    .clk(clk), .rst(rst), .sample(sample), .last_bit(last_sample),
    .lsb_first(lsb_first), .drop_rx(drop_rx), .miso(miso),
    .rx_push(rx_push), .rx_data(rx_data)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst(rst), .active(busy), .manual(cs_manual), .level(cs_level),
    .active_low(cs_active_low), .sel(cs_sel), .cs_out(cs_out)
  );

  // R10: completion is a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: completion coincides with the end of busy
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
  // R2: clock rests at polarity level while idle
  a_r2_sclk_rests: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (sclk == $past(cpol)));
  // R8: selected line active whenever the clock is off its rest level
  a_r8_cs_on_edges: assert property (@(posedge clk) disable iff (rst)
    (busy && !cs_manual && $stable(cs_sel) && (sclk != cpol)) |-> (cs_out[cs_sel] == !cs_active_low));
endmodule

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
  localparam int CNT_W = 8;
  localparam int NUM_CS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, master_mode = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic drop_rx = 1'b0, cs_manual = 1'b0, cs_level = 1'b0, cs_active_low = 1'b1;
  logic [1:0] cs_sel = 2'd0;
  logic start = 1'b0;
  logic [CNT_W-1:0] burst_len = '0, tx_len = '0;
  logic sclk_tick = 1'b0;
  logic tx_empty, tx_pop, rx_push, miso = 1'b0, sclk, mosi, busy, done;
  logic [7:0] tx_data, rx_data;
  logic [NUM_CS-1:0] cs_out;

  spi_burst_engine #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_spi_burst_engine (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] fifo_q [16];
  int nfifo = 0, rd_ptr = 0;
  logic [7:0] slave_q [64];
  logic mosi_bits [512];
  logic [7:0] rx_got [64];
  int edges = 0, nsamp = 0, nrx = 0, done_cnt = 0, cs_err = 0, busy_err = 0, tick_err = 0;
  logic prev_sclk = 1'b0, prev_tick = 1'b0;
  int tick_div = 0;

  assign tx_empty = (rd_ptr >= nfifo);
  assign tx_data  = tx_empty ? 8'h00 : fifo_q[rd_ptr];
  always @(posedge clk) if (tx_pop) rd_ptr <= rd_ptr + 1;

  function automatic logic slave_bit(int n);
    int k = n / 8, b = n % 8;
    if (k >= int'(burst_len)) return 1'b0;
    return lsb_first ? slave_q[k][b] : slave_q[k][7-b];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // half-period enable every third cycle
  initial forever begin
    @(negedge clk);
    tick_div = (tick_div + 1) % 3;
    sclk_tick = (tick_div == 2);
  end

  // pin monitor and slave model
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (sclk != prev_sclk) begin
        edges++;
        if (!prev_tick) tick_err++;
        if (!busy) busy_err++;
        if (!cs_manual) begin
          for (int i = 0; i < NUM_CS; i++)
            if (cs_out[i] !== ((i == int'(cs_sel)) ? !cs_active_low : cs_active_low)) cs_err++;
        end
        if (cpha ? (sclk == cpol) : (sclk != cpol)) begin
          mosi_bits[nsamp] = mosi;
          nsamp++;
        end
      end
      if (done) begin
        done_cnt++;
        if (busy) busy_err++;
      end
      if (rx_push && nrx < 64) begin
        rx_got[nrx] = rx_data;
        nrx++;
      end
    end
    prev_sclk = sclk;
    prev_tick = sclk_tick;
    miso = slave_bit(nsamp);
  end

  task automatic clear_mon();
    edges = 0; nsamp = 0; nrx = 0; done_cnt = 0; cs_err = 0; busy_err = 0; tick_err = 0;
    rd_ptr = 0;
  endtask

  task automatic run_xfer(input bit p, input bit h, input bit l, input int bl, input int tl,
                          input int nf, input bit dr, input int sel, input bit alow, input int seed);
    int guard = 0;
    int pops_exp, bad;
    @(negedge clk);
    cpol = p; cpha = h; lsb_first = l; drop_rx = dr; cs_sel = 2'(sel); cs_active_low = alow;
    burst_len = CNT_W'(bl); tx_len = CNT_W'(tl); cs_manual = 1'b0;
    for (int i = 0; i < 16; i++) fifo_q[i] = 8'((i * 37 + 11 + seed * 5) & 255);
    for (int i = 0; i < 64; i++) slave_q[i] = 8'((i * 53 + 7 + seed * 29) & 255);
    nfifo = nf;
    repeat (3) @(negedge clk);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == 0 && guard < 6000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    // R10 and R1
    chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
    chk(busy_err == 0 && !busy, "R1 busy span", busy_err, 0);
    // R2
    chk(edges == 16 * bl, "R2 sclk edge count", edges, 16 * bl);
    chk(tick_err == 0 && sclk == p, "R2 edges on tick, rest level", tick_err, 0);
    // R3 R4 R5 transmitted words
    bad = -1;
    for (int k = 0; k < bl; k++) begin
      logic [7:0] got, exp;
      exp = (k < tl && k < nf) ? fifo_q[k] : 8'h00;
      for (int b = 0; b < 8; b++)
        if (l) got[b] = mosi_bits[k*8+b]; else got[7-b] = mosi_bits[k*8+b];
      if (got !== exp && bad < 0) begin
        bad = k;
        chk(0, "R3 R4 R5 mosi word", int'(got), int'(exp));
      end
    end
    if (bad < 0) chk(1, "R3 mosi words", 0, 0);
    pops_exp = (tl < bl) ? tl : bl;
    if (nf < pops_exp) pops_exp = nf;
    chk(rd_ptr == pops_exp, "R4 R5 pop count", rd_ptr, pops_exp);
    // R6 R7 received words
    if (dr) chk(nrx == 0, "R7 no push when dropping", nrx, 0);
    else begin
      chk(nrx == bl, "R6 push count", nrx, bl);
      for (int k = 0; k < bl && k < nrx; k++)
        if (rx_got[k] !== slave_q[k]) chk(0, "R6 rx word", int'(rx_got[k]), int'(slave_q[k]));
    end
    // R8 R9
    chk(cs_err == 0, "R8 cs active on edges", cs_err, 0);
    chk(cs_out == (alow ? 4'hF : 4'h0), "R9 cs rest level", int'(cs_out), alow ? 15 : 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !tx_pop && !rx_push, "R1 reset idle", int'(busy), 0);
    chk(cs_out == 4'hF, "R9 reset cs", int'(cs_out), 15);
    chk(sclk == 1'b0, "R2 reset sclk", int'(sclk), 0);
    // R1: start ignored when disabled or not master
    burst_len = 8'd2; tx_len = 8'd2;
    en = 1'b0; master_mode = 1'b1;
    for (int g = 0; g < 2; g++) begin
      clear_mon();
      nfifo = 4;
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (60) @(negedge clk);
      chk(edges == 0 && done_cnt == 0 && !busy && rd_ptr == 0, "R1 start ignored", edges, 0);
      en = 1'b1; master_mode = 1'b0;
    end
    master_mode = 1'b1;
    // sweep of modes and orderings
    for (int m = 0; m < 8; m++)
      run_xfer(m[1], m[0], m[2], 3, 2, 5, m[0] & m[2], m % 4, m[1] ^ m[2] ? 1'b0 : 1'b1, m);
    // boundaries
    run_xfer(0, 0, 0, 2, 0, 4, 0, 1, 1, 20);   // R4 no FIFO words
    run_xfer(1, 1, 1, 4, 3, 1, 0, 2, 1, 21);   // R5 FIFO runs dry
    run_xfer(0, 1, 0, 2, 9, 8, 0, 3, 0, 22);   // R4 tx_len beyond burst
    run_xfer(1, 0, 1, 1, 1, 1, 0, 0, 1, 23);   // single word
    // R9 manual chip select
    cs_manual = 1'b1; cs_sel = 2'd2; cs_active_low = 1'b1; cs_level = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_out == 4'b1011, "R9 manual low", int'(cs_out), 11);
    cs_level = 1'b1; cs_active_low = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_out == 4'b0100, "R9 manual high, active-high rest", int'(cs_out), 4);
    cs_manual = 1'b0; cs_active_low = 1'b1;
    // R11 abort
    cpol = 1'b1; cpha = 1'b0; burst_len = 8'd4; tx_len = 8'd0;
    repeat (2) @(negedge clk);
    clear_mon();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && sclk == 1'b1 && done_cnt == 0, "R11 abort", done_cnt, 0);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk(done_cnt == 0 && !busy, "R11 no late done", done_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule